// File: doc/BRIEF.md
# Two-Tier Interrupt Arbiter

This block decides which pending interrupt group a processor core services next. Request flags are bundled into groups. Each group has a fixed natural index, which is its position in the flag vector, and a programmable two-bit urgency level. Arbitration runs in two tiers. The most urgent level among eligible groups is found first. Among the groups at that level, the lowest natural index wins. The winner's group number and its vector address are registered and presented with a one-cycle take strobe. No further grant is made until the core acknowledges.

Some cycles must not be interrupted. A prefix-register write or a code-pointer memory access marks the cycle after it as non-interruptible. A request that would have been granted in that cycle is delayed by exactly one cycle and is not lost. A request that cannot be handled normally is sent to a fixed catch-all vector. This happens when its group is disabled at the moment the request rises, or when it is a medium-urgency request that rises while the core is stopped. Clearing flags is left to software, which is modelled by the bench.

Top module: `irq_arbiter`

## Requirements
- R1: Among eligible groups, the group whose level field (2 bits per group, group g at bits 2g+1:2g of `grp_lvl_i`) has the smaller value is granted first, whatever its natural index.
- R2: When eligible groups share the best level, the group with the smaller natural index (group number) is granted first.
- R3: Group g owns flags FPG*g to FPG*g+FPG-1 (FPG = 2 by default). Any one of them makes the group pending, and the reported ID is the group number g, not the flag number.
- R4: `take_o` is high for exactly one cycle per grant. `src_id_o` and `vec_o` change only with a take. A normal grant of group g carries vector VEC_BASE + g*VEC_STRIDE (0x100 + g*0x10 by default).
- R5: After a take, no further take occurs until `ack_i` has been sampled high. The earliest next take is in the cycle after the acknowledge cycle.
- R6: When `pfx_wr_i` is high in cycle c, no take can result from cycle c+1. A request first present in cycle c+1 is granted one cycle later than it would otherwise be.
- R7: `cp_acc_i` opens the same one-cycle window as R6, with the same single-cycle deferral.
- R8: While `gie_i` is low, no take occurs. Pending requests, including catch-all ones, are granted once `gie_i` returns high.
- R9: A group request that rises while its bit in `grp_en_i` is 0 produces a catch-all grant with ID N_GRP (8 by default) and vector 0x98. A disabled group that stays pending does not produce a second grant.
- R10: While `stop_i` is high, a request of medium level (1 or 2) that rises produces a catch-all grant. Medium groups are excluded from normal arbitration, and levels 0 and 3 arbitrate normally.
- R11: A catch-all grant takes precedence over any normal pending request.
- R12: After reset, `take_o`, `src_id_o` and `vec_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_flag_i | input | N_GRP*FPG | Request flags, grouped by natural index |
| grp_en_i | input | N_GRP | Per-group enable |
| grp_lvl_i | input | N_GRP*LVL_W | Per-group level, 0 = most urgent |
| gie_i | input | 1 | Global interrupt enable |
| stop_i | input | 1 | Core is in stop mode |
| pfx_wr_i | input | 1 | Prefix register written this cycle |
| cp_acc_i | input | 1 | Code-pointer memory access this cycle |
| ack_i | input | 1 | Core acknowledges the last take |
| take_o | output | 1 | One-cycle grant strobe |
| src_id_o | output | ID_W | Granted group, N_GRP for catch-all |
| vec_o | output | VEC_W | Granted vector address |

## Verification
A wrong level minimum or index scan appears as the wrong ID on the first take of a contended pair, in the cycle right after the requests arrive. A stuck busy or window register shows as a missing take, or one that comes a cycle early or late, relative to an acknowledge or a prefix or code-pointer pulse. A lost catch-all latch shows as an absent 0x98 grant once the global enable returns. Each of these appears within two cycles of the causing stimulus.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    GK_NONE   = 2'd0,
    GK_NORMAL = 2'd1,
    GK_CATCH  = 2'd2
  } grant_kind_e;

  // medium urgency: neither the most urgent nor the least urgent code
  function automatic logic lvl_is_medium(input logic [1:0] lvl);
    return (lvl != 2'd0) && (lvl != 2'd3);
  endfunction

endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int N_GRP = 8,
  parameter int FPG   = 2,
  parameter int LVL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_GRP*FPG-1:0]   flag_i,
  input  logic [N_GRP-1:0]       en_i,
  input  logic [N_GRP*LVL_W-1:0] lvl_i,
  input  logic                   stop_i,
  output logic [N_GRP-1:0]       elig_o,
  output logic                   unh_set_o
);
  import irq_arb_pkg::*;

  logic [N_GRP-1:0] pend;
  logic [N_GRP-1:0] pend_q;
  logic [N_GRP-1:0] unh_hit;

  genvar g;
  generate
    for (g = 0; g < N_GRP; g++) begin : g_grp
      logic [LVL_W-1:0] lvl;
      logic             med;
      logic             stop_block;
      assign lvl        = lvl_i[g*LVL_W +: LVL_W];
      assign med        = lvl_is_medium(2'(lvl));
      assign stop_block = stop_i & med;
      assign pend[g]    = |flag_i[g*FPG +: FPG];
      assign elig_o[g]  = pend[g] & en_i[g] & ~stop_block;
      assign unh_hit[g] = pend[g] & ~pend_q[g] & (~en_i[g] | stop_block);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend;
  end

  assign unh_set_o = |unh_hit;

endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int N_GRP = 8,
  parameter int LVL_W = 2,
  parameter int ID_W  = 4
) (
  input  logic [N_GRP-1:0]       elig_i,
  input  logic [N_GRP*LVL_W-1:0] lvl_i,
  output logic                   any_o,
  output logic [ID_W-1:0]        win_o
);
  logic [LVL_W-1:0] best;
  logic             found;

  // tier one: most urgent level among eligible groups
  always_comb begin
    best = '1;
    for (int i = 0; i < N_GRP; i++) begin
      if (elig_i[i] && (lvl_i[i*LVL_W +: LVL_W] < best))
        best = lvl_i[i*LVL_W +: LVL_W];
    end
  end

  // tier two: lowest natural index at that level
  always_comb begin
    win_o = '0;
    found = 1'b0;
    for (int i = 0; i < N_GRP; i++) begin
      if (!found && elig_i[i] && (lvl_i[i*LVL_W +: LVL_W] == best)) begin
        win_o = ID_W'(i);
        found = 1'b1;
      end
    end
  end

  assign any_o = |elig_i;

endmodule

// File: rtl/irq_grant_ctl.sv
module irq_grant_ctl #(
  parameter int               N_GRP      = 8,
  parameter int               ID_W       = 4,
  parameter int               VEC_W      = 16,
  parameter logic [VEC_W-1:0] VEC_BASE   = 16'h0100,
  parameter logic [VEC_W-1:0] VEC_STRIDE = 16'h0010,
  parameter logic [VEC_W-1:0] CATCH_VEC  = 16'h0098
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gie_i,
  input  logic             pfx_wr_i,
  input  logic             cp_acc_i,
  input  logic             ack_i,
  input  logic             any_i,
  input  logic [ID_W-1:0]  win_i,
  input  logic             unh_set_i,
  output logic             take_o,
  output logic [ID_W-1:0]  id_o,
  output logic [VEC_W-1:0] vec_o
);
  import irq_arb_pkg::*;

  localparam logic [ID_W-1:0] CATCH_ID = ID_W'(N_GRP);

  logic        win_q;
  logic        busy_q;
  logic        unh_q;
  logic        can;
  logic        unh_pend;
  grant_kind_e kind;

  assign can      = gie_i & ~busy_q & ~win_q;
  assign unh_pend = unh_q | unh_set_i;

  always_comb begin
    kind = GK_NONE;
    if (can) begin
      if (unh_pend)   kind = GK_CATCH;
      else if (any_i) kind = GK_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= 1'b0;
      busy_q <= 1'b0;
      unh_q  <= 1'b0;
      take_o <= 1'b0;
      id_o   <= '0;
      vec_o  <= '0;
    end else begin
      win_q  <= pfx_wr_i | cp_acc_i;
      take_o <= (kind != GK_NONE);
      unh_q  <= (kind == GK_CATCH) ? 1'b0 : unh_pend;
      if (kind != GK_NONE)  busy_q <= 1'b1;
      else if (ack_i)       busy_q <= 1'b0;
      case (kind)
        GK_CATCH: begin
          id_o  <= CATCH_ID;
          vec_o <= CATCH_VEC;
        end
        GK_NORMAL: begin
          id_o  <= win_i;
          vec_o <= VEC_BASE + VEC_W'(win_i) * VEC_STRIDE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int               N_GRP      = 8,
  parameter int               FPG        = 2,
  parameter int               LVL_W      = 2,
  parameter int               VEC_W      = 16,
  parameter logic [VEC_W-1:0] VEC_BASE   = 16'h0100,
  parameter logic [VEC_W-1:0] VEC_STRIDE = 16'h0010,
  parameter logic [VEC_W-1:0] CATCH_VEC  = 16'h0098,
  localparam int              ID_W       = $clog2(N_GRP + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_GRP*FPG-1:0]   irq_flag_i,
  input  logic [N_GRP-1:0]       grp_en_i,
  input  logic [N_GRP*LVL_W-1:0] grp_lvl_i,
  input  logic                   gie_i,
  input  logic                   stop_i,
  input  logic                   pfx_wr_i,
  input  logic                   cp_acc_i,
  input  logic                   ack_i,
  output logic                   take_o,
  output logic [ID_W-1:0]        src_id_o,
  output logic [VEC_W-1:0]       vec_o
);
  logic [N_GRP-1:0] elig;
  logic             unh_set;
  logic             any_norm;
  logic [ID_W-1:0]  win_id;

  irq_src_cond #(.N_GRP(N_GRP), .FPG(FPG), .LVL_W(LVL_W)) u_cond (
    .clk       (clk),
    .rst       (rst),
    .flag_i    (irq_flag_i),
    .en_i      (grp_en_i),
    .lvl_i     (grp_lvl_i),
    .stop_i    (stop_i),
    .elig_o    (elig),
    .unh_set_o (unh_set)
  );

  irq_level_arb #(.N_GRP(N_GRP), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
    .elig_i (elig),
    .lvl_i  (grp_lvl_i),
    .any_o  (any_norm),
    .win_o  (win_id)
  );

  irq_grant_ctl #(
    .N_GRP(N_GRP), .ID_W(ID_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .CATCH_VEC(CATCH_VEC)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .gie_i     (gie_i),
    .pfx_wr_i  (pfx_wr_i),
    .cp_acc_i  (cp_acc_i),
    .ack_i     (ack_i),
    .any_i     (any_norm),
    .win_i     (win_id),
    .unh_set_i (unh_set),
    .take_o    (take_o),
    .id_o      (src_id_o),
    .vec_o     (vec_o)
  );

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int               N_GRP      = 8,
  parameter int               ID_W       = 4,
  parameter int               VEC_W      = 16,
  parameter logic [VEC_W-1:0] VEC_BASE   = 16'h0100,
  parameter logic [VEC_W-1:0] VEC_STRIDE = 16'h0010,
  parameter logic [VEC_W-1:0] CATCH_VEC  = 16'h0098
) (
  input logic             clk,
  input logic             rst,
  input logic             gie_i,
  input logic             pfx_wr_i,
  input logic             cp_acc_i,
  input logic             take_o,
  input logic [ID_W-1:0]  src_id_o,
  input logic [VEC_W-1:0] vec_o
);
  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o); // R4

  AST_ID_MOVES_WITH_TAKE: assert property (@(posedge clk) disable iff (rst)
    !$stable(src_id_o) |-> take_o); // R4

  AST_NORMAL_VEC_MAP: assert property (@(posedge clk) disable iff (rst)
    (take_o && (src_id_o < ID_W'(N_GRP))) |->
      (vec_o == VEC_BASE + VEC_W'(src_id_o) * VEC_STRIDE)); // R4

  AST_CATCH_VEC: assert property (@(posedge clk) disable iff (rst)
    (take_o && (src_id_o == ID_W'(N_GRP))) |-> (vec_o == CATCH_VEC)); // R9

  AST_PFX_WINDOW: assert property (@(posedge clk) disable iff (rst)
    pfx_wr_i |=> ##1 !take_o); // R6

  AST_CP_WINDOW: assert property (@(posedge clk) disable iff (rst)
    cp_acc_i |=> ##1 !take_o); // R7

  AST_GIE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> !take_o); // R8

endmodule

bind irq_arbiter irq_arbiter_chk #(
  .N_GRP(N_GRP), .ID_W(ID_W), .VEC_W(VEC_W),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .CATCH_VEC(CATCH_VEC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .gie_i    (gie_i),
  .pfx_wr_i (pfx_wr_i),
  .cp_acc_i (cp_acc_i),
  .take_o   (take_o),
  .src_id_o (src_id_o),
  .vec_o    (vec_o)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  localparam int NG = 8;
  localparam int FP = 2;
  localparam int IW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NG*FP-1:0] flags = '0;
  logic [NG-1:0]   en = '1;
  logic [NG*2-1:0] lvl = '1;
  logic            gie = 1'b1;
  logic            stop = 1'b0;
  logic            pfx = 1'b0;
  logic            cp = 1'b0;
  logic            ack = 1'b0;
  logic            take;
  logic [IW-1:0]   id;
  logic [15:0]     vec;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  irq_arbiter u0 (
    .clk(clk), .rst(rst), .irq_flag_i(flags), .grp_en_i(en), .grp_lvl_i(lvl),
    .gie_i(gie), .stop_i(stop), .pfx_wr_i(pfx), .cp_acc_i(cp), .ack_i(ack),
    .take_o(take), .src_id_o(id), .vec_o(vec)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [NG*FP-1:0] gmask(input int g);
    logic [NG*FP-1:0] m = '0;
    m[g*FP +: FP] = '1;
    return m;
  endfunction

  task automatic set_lvl(input int g, input logic [1:0] l);
    lvl[g*2 +: 2] = l;
  endtask

  task automatic ack_clear(input logic [NG*FP-1:0] m);
    flags = flags & ~m;
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic expect_take(input string req, input int eid);
    chk(take === 1'b1, req, int'(take), 1);
    chk(id === IW'(eid), req, int'(id), eid);
    chk(vec === ((eid == NG) ? 16'h0098 : 16'(16'h0100 + eid * 16'h10)), req, int'(vec),
        (eid == NG) ? 'h98 : ('h100 + eid * 'h10));
  endtask

  task automatic clean();
    flags = '0; en = '1; lvl = '1; gie = 1'b1; stop = 1'b0;
    pfx = 1'b0; cp = 1'b0; ack = 1'b0;
    step(); step();
  endtask

  task automatic t_reset();
    chk(take === 1'b0, "R12", int'(take), 0);
    chk(id === '0, "R12", int'(id), 0);
    chk(vec === '0, "R12", int'(vec), 0);
  endtask

  task automatic t_level();
    clean();
    set_lvl(5, 2'd0); set_lvl(1, 2'd2);
    flags = gmask(1) | gmask(5);
    step();
    expect_take("R1", 5);
    step(); step();
    chk(take === 1'b0, "R5", int'(take), 0);
    ack_clear(gmask(5));
    chk(take === 1'b0, "R5", int'(take), 0);
    step();
    expect_take("R1", 1);
    ack_clear(gmask(1));
  endtask

  task automatic t_tie();
    clean();
    set_lvl(6, 2'd2); set_lvl(4, 2'd2); set_lvl(2, 2'd3);
    flags = gmask(2) | gmask(4) | gmask(6);
    step();
    expect_take("R2", 4);
    ack_clear(gmask(4)); step();
    expect_take("R2", 6);
    ack_clear(gmask(6)); step();
    expect_take("R1", 2);
    ack_clear(gmask(2));
  endtask

  task automatic t_group();
    clean();
    flags[7] = 1'b1;
    step();
    expect_take("R3", 3);
    ack_clear(gmask(3));
  endtask

  task automatic t_window(input logic use_cp, input string req);
    clean();
    if (use_cp) cp = 1'b1; else pfx = 1'b1;
    step();
    cp = 1'b0; pfx = 1'b0;
    flags = gmask(0);
    step();
    chk(take === 1'b0, req, int'(take), 0);
    step();
    expect_take(req, 0);
    ack_clear(gmask(0));
  endtask

  task automatic t_gie();
    clean();
    gie = 1'b0;
    flags = gmask(3);
    step(); step(); step();
    chk(take === 1'b0, "R8", int'(take), 0);
    gie = 1'b1;
    step();
    expect_take("R8", 3);
    ack_clear(gmask(3));
  endtask

  task automatic t_disabled();
    clean();
    en[2] = 1'b0;
    flags = gmask(2);
    step();
    expect_take("R9", NG);
    ack_clear('0);
    step(); step();
    chk(take === 1'b0, "R9", int'(take), 0);
    flags = '0;
    step();
  endtask

  task automatic t_stop();
    clean();
    stop = 1'b1;
    set_lvl(3, 2'd1); set_lvl(0, 2'd0);
    flags = gmask(3);
    step();
    expect_take("R10", NG);
    ack_clear('0);
    step();
    chk(take === 1'b0, "R10", int'(take), 0);
    flags = flags | gmask(0);
    step();
    expect_take("R10", 0);
    ack_clear(gmask(0) | gmask(3));
    stop = 1'b0;
    step();
  endtask

  task automatic t_catch_first();
    clean();
    gie = 1'b0;
    set_lvl(1, 2'd0);
    en[7] = 1'b0;
    flags = gmask(1) | gmask(7);
    step(); step();
    chk(take === 1'b0, "R8", int'(take), 0);
    gie = 1'b1;
    step();
    expect_take("R11", NG);
    ack_clear(gmask(7)); step();
    expect_take("R11", 1);
    ack_clear(gmask(1));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    t_reset();
    t_level();
    t_tie();
    t_group();
    t_window(1'b0, "R6");
    t_window(1'b1, "R7");
    t_gie();
    t_disabled();
    t_stop();
    t_catch_first();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule